// File: doc/BRIEF.md
# Bit-Serial Two's Complementer

This block negates one N-bit word at a time, one bit per clock. A word is written through a parallel port and held in a rotating shift register. A start pulse presets a one-bit carry register to one. The block then streams the word's two's complement out least significant bit first. Each output bit is the sum of a half-adder whose inputs are the inverted stored bit and the carry. The half-adder's carry-out becomes the carry for the next bit. The same serial bits are collected into a parallel result register.

A run lasts exactly N cycles. At the end, a one-cycle done pulse marks the result as complete, and the result then stays unchanged until the next start. A parallel load always wins: it replaces the stored word and cancels any run in progress. Because the shift register rotates rather than drains, the stored word is intact after a run, so starting again without a reload repeats the same result.

Top module: `serneg_top`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) leaves ser_valid, ser_bit, done and result all zero and the stored word zero.
- R2: With load_en high at an edge, load_word replaces the stored word. Any run in progress stops, so ser_valid is low from the next cycle and no done pulse follows. A start in the same cycle is ignored.
- R3: A start while idle and without load_en sets the carry to one. ser_valid is then high for exactly N consecutive cycles, beginning the cycle after the start edge.
- R4: In the k-th valid cycle (k = 0 first), ser_bit equals (NOT w[k]) XOR c, where w is the stored word. The carry c starts at one and after each bit becomes (NOT w[k]) AND c.
- R5: The serial result keeps every bit of the word up to and including its lowest 1 and inverts every bit above it. For N = 6, input 001010 gives 110110.
- R6: done is high for exactly one cycle, the cycle after the last valid bit, with ser_valid low. In that cycle, result bit k equals the k-th serial bit.
- R7: Outside a run, result does not change, even when a new word is loaded.
- R8: A start that arrives while a run is in progress is ignored: the run and its done timing are unchanged.
- R9: An all-zero word yields all zeros and the word 1 followed by zeros yields itself. Neither case raises any flag.
- R10: The stored word survives a run, so a second start without a reload produces the same result.
- R11: ser_bit is zero whenever ser_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Parallel load strobe; highest priority |
| load_word | input | W | Word to be negated |
| start | input | 1 | Begins a run when idle |
| ser_bit | output | 1 | Current complement bit, LSB first |
| ser_valid | output | 1 | High during the W shift cycles |
| done | output | 1 | One-cycle pulse after the last bit |
| result | output | W | Assembled two's complement, held after done |

## Verification
The bench drives words whose lowest 1 sits at the bottom, in the middle and at the top, plus all-zero and all-ones words. A carry that is not preset to one, or is not cleared after the first 1, shows up as wrong serial bits on these patterns. The bench also cancels a run with a load, presents load and start together, and raises start during a run. A design that gives priority to the wrong strobe would emit a done pulse or a stale result, and one that re-arms on a stray start would shift its done cycle. Repeating a start without a reload catches a shift register that drains instead of rotating, and a reset in the middle of a run catches state that survives reset.

// File: rtl/serneg_pkg.sv
// Shared types for the bit-serial two's complementer.
package serneg_pkg;

    // Controller phase: waiting for a start, or streaming bits.
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } serneg_phase_t;

endpackage

// File: rtl/serneg_shift_reg.sv
// Holds the word to be negated and rotates it right by one bit per shift.
// The bit leaving at the LSB re-enters at the MSB, so the word is intact
// after W shifts. Assumes load_en and shift_en are never used together
// (the controller drops shift_en when a load arrives).
module serneg_shift_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_word,
    input  logic         shift_en,
    output logic         lsb
);

    logic [W-1:0] word_q;

    generate
        if (W > 1) begin : g_rotate
            // Capture on load, otherwise rotate right when enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (load_en)
                    word_q <= load_word;
                else if (shift_en)
                    word_q <= {word_q[0], word_q[W-1:1]};
            end
        end else begin : g_single
            // A one-bit word is unchanged by rotation.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (load_en)
                    word_q <= load_word;
            end
        end
    endgenerate

    assign lsb = word_q[0];

    // After a full rotation the word is back in place: a loaded word
    // still reads out its LSB when idle. Guarded on the loaded value.
    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (lsb == $past(load_word[0])));  // R2

endmodule

// File: rtl/serneg_carry_cell.sv
// Serial half-adder on the inverted data bit plus the carry register.
// sum = ~bit ^ carry, carry_next = ~bit & carry. The carry is preset to
// one at the start of every word so the first step adds one.
// Assumes preset and step are not both high.
module serneg_carry_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic preset,
    input  logic step,
    input  logic bit_in,
    output logic sum_out
);

    logic carry_q;
    logic inv_bit;
    logic carry_out;

    // Half-adder on the inverted bit and the stored carry.
    always_comb begin
        inv_bit   = ~bit_in;
        sum_out   = inv_bit ^ carry_q;
        carry_out = inv_bit & carry_q;
    end

    // Carry register: preset on a new word, otherwise advance per bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b1;
        else if (preset)
            carry_q <= 1'b1;
        else if (step)
            carry_q <= carry_out;
    end

    AST_PRESET_SETS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> carry_q);  // R3

    AST_CARRY_NO_REVIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry_q && !preset) |=> !carry_q);  // R5

    AST_CARRY_FALLS_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !preset && bit_in) |=> !carry_q);  // R4

endmodule

// File: rtl/serneg_ctrl.sv
// Run controller. A start while idle (and without a load) presets the carry
// and opens a window of exactly W shift cycles; done pulses once after the
// last one. A load aborts a run and beats a simultaneous start. A start
// during a run is ignored.
module serneg_ctrl
    import serneg_pkg::*;
#(
    parameter int W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic start,
    output logic busy,
    output logic preset,
    output logic done
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    serneg_phase_t phase_q;
    logic [CW-1:0] count_q;
    logic          done_q;

    // Carry preset happens exactly when a run is accepted.
    always_comb begin
        preset = start && !load_en && (phase_q == PH_IDLE);
        busy   = (phase_q == PH_SHIFT);
        done   = done_q;
    end

    // Phase, bit counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            count_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_en) begin
                phase_q <= PH_IDLE;
                count_q <= '0;
            end else begin
                case (phase_q)
                    PH_IDLE: begin
                        if (start) begin
                            phase_q <= PH_SHIFT;
                            count_q <= '0;
                        end
                    end
                    PH_SHIFT: begin
                        if (count_q == LAST) begin
                            phase_q <= PH_IDLE;
                            count_q <= '0;
                            done_q  <= 1'b1;
                        end else begin
                            count_q <= count_q + 1'b1;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    AST_LOAD_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (!busy && !done));  // R2

    AST_START_OPENS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> busy);  // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R6

    AST_DONE_CLOSES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);  // R6

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !preset);  // R8

endmodule

// File: rtl/serneg_collect.sv
// Assembles the serial complement bits into a parallel word. Each bit
// enters at the MSB and moves down, so after W shifts bit k of the result
// is the k-th serial bit. Holds its value whenever shift_en is low.
module serneg_collect #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] result
);

    logic [W-1:0] res_q;

    generate
        if (W > 1) begin : g_chain
            // Shift the new bit in from the top.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    res_q <= '0;
                else if (shift_en)
                    res_q <= {bit_in, res_q[W-1:1]};
            end
        end else begin : g_single
            // One-bit result takes the bit directly.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    res_q <= '0;
                else if (shift_en)
                    res_q <= bit_in;
            end
        end
    endgenerate

    assign result = res_q;

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(result));  // R7

endmodule

// File: rtl/serneg_top.sv
// Bit-serial two's complementer. Loads a W-bit word, then on start streams
// its two's complement LSB first through one carry register and a
// half-adder, collecting the bits into a parallel result.
// Assumes a synchronous active-low reset and a single clock.
module serneg_top #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_word,
    input  logic         start,
    output logic         ser_bit,
    output logic         ser_valid,
    output logic         done,
    output logic [W-1:0] result
);

    logic busy;
    logic preset;
    logic cur_lsb;
    logic sum_bit;
    logic shift_en;

    serneg_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .start   (start),
        .busy    (busy),
        .preset  (preset),
        .done    (done)
    );

    serneg_shift_reg #(.W(W)) u_sreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_word (load_word),
        .shift_en  (shift_en),
        .lsb       (cur_lsb)
    );

    serneg_carry_cell u_carry (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (preset),
        .step    (shift_en),
        .bit_in  (cur_lsb),
        .sum_out (sum_bit)
    );

    serneg_collect #(.W(W)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (sum_bit),
        .result   (result)
    );

    // Shifting happens only inside a run that is not being aborted.
    always_comb begin
        shift_en  = busy && !load_en;
        ser_valid = busy;
        ser_bit   = busy & sum_bit;
    end

    AST_FIRST_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && cur_lsb) |=> (!ser_valid || ser_bit));  // R5

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ser_valid));  // R6

endmodule

// File: tb/serneg_top_bench.sv
`timescale 1ns/1ps
module serneg_top_bench;

    localparam int W = 6;
    localparam int NV = 8;

    // Stimulus / expected pairs for W = 6.
    localparam logic [W-1:0] VIN  [NV] = '{6'b001010, 6'b000000, 6'b100000, 6'b000001,
                                           6'b111111, 6'b011111, 6'b010100, 6'b000110};
    localparam logic [W-1:0] VEXP [NV] = '{6'b110110, 6'b000000, 6'b100000, 6'b111111,
                                           6'b000001, 6'b100001, 6'b101100, 6'b111010};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic [W-1:0] load_word = '0;
    logic         start = 1'b0;
    logic         ser_bit;
    logic         ser_valid;
    logic         done;
    logic [W-1:0] result;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    serneg_top #(.W(W)) u_serneg_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_word (load_word),
        .start     (start),
        .ser_bit   (ser_bit),
        .ser_valid (ser_valid),
        .done      (done),
        .result    (result)
    );

    always #4 clk = ~clk;  // 125 MHz

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            finish_run();
        end
    end

    task automatic do_load(input logic [W-1:0] x);
        load_en   = 1'b1;
        load_word = x;
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Called at the negedge just after the start edge. poke >= 0 raises
    // start for one cycle in that valid cycle (R8).
    task automatic watch_run(input logic [W-1:0] e, input int poke);
        for (int k = 0; k < W; k++) begin
            check($sformatf("R3 valid bit %0d", k), ser_valid, 1'b1);
            check($sformatf("R4 R5 serial bit %0d", k), ser_bit, e[k]);
            check("R6 no early done", done, 1'b0);
            if (k == poke) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        check("R6 done pulse", done, 1'b1);
        check("R3 valid ends", ser_valid, 1'b0);
        check("R11 quiet bit", ser_bit, 1'b0);
        check("R6 result", result, e);
        @(negedge clk);
        check("R6 done one cycle", done, 1'b0);
        check("R7 result held", result, e);
    endtask

    initial begin
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        check("R1 ser_valid", ser_valid, 1'b0);
        check("R1 done", done, 1'b0);
        check("R1 ser_bit", ser_bit, 1'b0);
        check("R1 result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: stored word is zero, so a start yields zeros
        do_start();
        watch_run('0, -1);

        // Table walk: R4, R5, R9
        for (int v = 0; v < NV; v++) begin
            do_load(VIN[v]);
            do_start();
            watch_run(VEXP[v], -1);
        end

        // R10: restart without reload repeats the last result
        do_start();
        watch_run(VEXP[NV-1], -1);

        // R7: a new load leaves the result unchanged
        do_load(VIN[0]);
        repeat (3) @(negedge clk);
        check("R7 result after load", result, VEXP[NV-1]);
        check("R11 idle bit", ser_bit, 1'b0);

        // R8: start during a run is ignored
        do_start();
        watch_run(VEXP[0], 2);

        // R2: load aborts a run
        do_load(VIN[3]);
        do_start();
        @(negedge clk);
        @(negedge clk);
        do_load(VIN[6]);
        check("R2 abort valid", ser_valid, 1'b0);
        begin
            logic seen = 1'b0;
            for (int k = 0; k < W + 2; k++) begin
                if (done) seen = 1'b1;
                @(negedge clk);
            end
            check("R2 no done after abort", seen, 1'b0);
        end
        do_start();
        watch_run(VEXP[6], -1);

        // R2: load beats a simultaneous start
        load_en   = 1'b1;
        start     = 1'b1;
        load_word = VIN[5];
        @(negedge clk);
        load_en = 1'b0;
        start   = 1'b0;
        check("R2 load wins", ser_valid, 1'b0);
        @(negedge clk);
        check("R2 still idle", ser_valid, 1'b0);
        do_start();
        watch_run(VEXP[5], -1);

        // R1: reset in the middle of a run
        do_load(VIN[7]);
        do_start();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset valid", ser_valid, 1'b0);
        check("R1 mid reset done", done, 1'b0);
        check("R1 mid reset result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        do_start();
        watch_run('0, -1);

        finish_run();
    end

endmodule